// File: doc/BRIEF.md
# Sub-addressed bank and interrupt-enable register file

This block sits on the CPU write path of a cartridge-style memory controller. Every register lives in one 4 KB page selected by the top address nibble. Address bits 9:8 split that page into four sub-spaces: a program-bank nibble port, a control port, a program-bank byte port and a pattern-bank port. In the byte ports the low address bits select the target register. The block holds three program bank registers: bank a, bank b, and a bank for the low (0x6000) window. It also holds a 3-bit program mode, two mirroring bits, an enable that maps ROM into the low window, the interrupt enable latch and eight 9-bit pattern (graphics) bank registers.

A static configuration byte selects between two pattern-bank layouts. In the plain layout eight registers take a byte each at 1 KB granularity. In the wide layout four of the registers take the byte one bit higher, at 2 KB granularity, and they sit at sub-addresses that are not contiguous. The interrupt counter is outside this block. Only its enable latch is kept here. Every register is a flop that is updated on the clock edge of the write and is visible on the outputs from the next cycle on.

Top module: `bankreg_regfile`

## Requirements
- R1: After reset, every output register reads zero.
- R2: A register changes only in a cycle where `wr_en` is 1 and `addr[15:12]` equals the page number (default 4'h8). Any other cycle leaves every output unchanged.
- R3: In sub-space `addr[9:8]`=00, `wdata[3:0]` is written into `prg_a_o[4:1]`, and the other bits of `prg_a_o` keep their value.
- R4: In sub-space 01, `mirror_o` takes `wdata[1:0]`, `prg_mode_o[2]` takes `wdata[4]`, `rom_lo_en_o` takes `wdata[5]` and `irq_en_o` takes `wdata[7]`. `prg_mode_o[1:0]` is not changed.
- R5: In sub-space 10, `addr[1:0]` selects the target: 00 writes the whole byte to `prg_a_o`, 01 and 10 both write it to `prg_b_o`, and 11 writes it to `prg_win_o`.
- R6: In sub-space 11 with the wide-layout flag clear, `addr[2:0]`=k writes `wdata` into bits 7:0 of pattern bank k (field `pat_bank_o[9k+8:9k]`). Bit 8 of that bank keeps its value.
- R7: In sub-space 11 with the wide-layout flag set, sub-addresses 0, 1, 6 and 7 write `wdata` into bits 8:1 of pattern banks 0, 2, 4 and 6, and bit 0 of the bank keeps its value. Sub-addresses 2 to 5 change nothing.
- R8: The wide-layout flag is `cfg[2]`. It is taken from the cycle of each write, so consecutive writes may use different layouts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Qualified CPU write cycle |
| addr | input | 16 | CPU address |
| wdata | input | 8 | CPU write data |
| cfg | input | 8 | Static configuration; bit 2 selects the wide pattern layout |
| prg_a_o | output | 8 | Program bank a |
| prg_b_o | output | 8 | Program bank b |
| prg_win_o | output | 8 | Bank for the low ROM window |
| prg_mode_o | output | 3 | Program mode |
| mirror_o | output | 2 | Mirroring select |
| rom_lo_en_o | output | 1 | Map ROM into the low window |
| irq_en_o | output | 1 | Interrupt enable latch |
| pat_bank_o | output | 72 | Eight 9-bit pattern banks, bank k in bits 9k+8:9k |

## Verification
The properties assume that `wr_en`, `addr`, `wdata` and `cfg` are steady and known at each rising edge while reset is released. They also assume that a write lasts exactly one cycle in the sense that every asserted cycle is a separate write. The bench changes inputs only on falling edges and always drives defined values. It raises `wr_en` for single cycles and also in back-to-back runs. Its random phase limits addresses to the decoded page plus a few neighbouring pages, so both hits and misses occur. It draws `cfg[2]` afresh on every write.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;
    localparam int DW        = 8;
    localparam int PRG_W     = 8;
    localparam int PAT_W     = DW + 1;
    localparam int NUM_PAT   = 8;
    localparam int PAT_SEL_W = $clog2(NUM_PAT);
    localparam int NUM_PRG   = 4;
    localparam int ALT_BIT   = 2;

    typedef enum logic [1:0] {
        SUB_NIBBLE = 2'b00,
        SUB_CTRL   = 2'b01,
        SUB_PRG    = 2'b10,
        SUB_PAT    = 2'b11
    } subspace_e;

    typedef struct packed {
        logic                nibble;
        logic                ctrl;
        logic [NUM_PRG-1:0]  prg;
        logic [NUM_PAT-1:0]  pat;
    } strobe_t;

    typedef struct packed {
        logic [PRG_W-1:0] prg_a;
        logic [PRG_W-1:0] prg_b;
        logic [PRG_W-1:0] prg_win;
        logic [2:0]       prg_mode;
        logic [1:0]       mirror;
        logic             rom_lo_en;
        logic             irq_en;
    } ctl_regs_t;

    typedef struct packed {
        ctl_regs_t                       ctl;
        logic [NUM_PAT-1:0][PAT_W-1:0]   pat;
    } regs_t;
endpackage

// File: rtl/bankreg_decode.sv
module bankreg_decode
    import bankreg_pkg::*;
#(
    parameter logic [3:0] PAGE_ID = 4'h8
) (
    input  logic        wr_en,
    input  logic [15:0] addr,
    output strobe_t     stb
);
    logic hit;

    always_comb begin
        hit = wr_en && (addr[15:12] == PAGE_ID);
        stb = '0;
        if (hit) begin
            unique case (subspace_e'(addr[9:8]))
                SUB_NIBBLE: stb.nibble = 1'b1;
                SUB_CTRL:   stb.ctrl   = 1'b1;
                SUB_PRG:    stb.prg[addr[1:0]] = 1'b1;
                SUB_PAT:    stb.pat[addr[PAT_SEL_W-1:0]] = 1'b1;
                default:    stb = '0;
            endcase
        end
    end
endmodule

// File: rtl/bankreg_ctlnext.sv
module bankreg_ctlnext
    import bankreg_pkg::*;
(
    input  strobe_t         stb,
    input  logic [DW-1:0]   wdata,
    input  ctl_regs_t       cur,
    output ctl_regs_t       nxt
);
    always_comb begin
        nxt = cur;
        if (stb.nibble) begin
            nxt.prg_a[4:1] = wdata[3:0];
        end
        if (stb.ctrl) begin
            nxt.mirror      = wdata[1:0];
            nxt.prg_mode[2] = wdata[4];
            nxt.rom_lo_en   = wdata[5];
            nxt.irq_en      = wdata[7];
        end
        if (stb.prg[0]) begin
            nxt.prg_a = PRG_W'(wdata);
        end
        if (stb.prg[1] || stb.prg[2]) begin
            nxt.prg_b = PRG_W'(wdata);
        end
        if (stb.prg[3]) begin
            nxt.prg_win = PRG_W'(wdata);
        end
    end
endmodule

// File: rtl/bankreg_patlane.sv
module bankreg_patlane
    import bankreg_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic               wide,
    input  logic [NUM_PAT-1:0] sel,
    input  logic [DW-1:0]      wdata,
    input  logic [PAT_W-1:0]   cur,
    output logic [PAT_W-1:0]   nxt
);
    logic wide_hit;

    generate
        if (IDX % 2 == 0) begin : g_wide
            localparam int WIDE_SUB = (IDX < NUM_PAT / 2) ? IDX / 2 : IDX / 2 + NUM_PAT / 2;
            assign wide_hit = sel[WIDE_SUB];
        end else begin : g_narrow
            assign wide_hit = 1'b0;
        end
    endgenerate

    always_comb begin
        nxt = cur;
        if (!wide) begin
            if (sel[IDX]) nxt[DW-1:0] = wdata;
        end else if (wide_hit) begin
            nxt[PAT_W-1:1] = wdata;
        end
    end
endmodule

// File: rtl/bankreg_regfile.sv
module bankreg_regfile
    import bankreg_pkg::*;
#(
    parameter logic [3:0] PAGE_ID = 4'h8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [15:0]              addr,
    input  logic [DW-1:0]            wdata,
    input  logic [7:0]               cfg,
    output logic [PRG_W-1:0]         prg_a_o,
    output logic [PRG_W-1:0]         prg_b_o,
    output logic [PRG_W-1:0]         prg_win_o,
    output logic [2:0]               prg_mode_o,
    output logic [1:0]               mirror_o,
    output logic                     rom_lo_en_o,
    output logic                     irq_en_o,
    output logic [NUM_PAT*PAT_W-1:0] pat_bank_o
);
    strobe_t                       stb;
    ctl_regs_t                     ctl_nxt;
    logic [NUM_PAT-1:0][PAT_W-1:0] pat_nxt;
    regs_t                         state_d, state_q;

    bankreg_decode #(.PAGE_ID(PAGE_ID)) u_dec (
        .wr_en (wr_en),
        .addr  (addr),
        .stb   (stb)
    );

    bankreg_ctlnext u_ctl (
        .stb   (stb),
        .wdata (wdata),
        .cur   (state_q.ctl),
        .nxt   (ctl_nxt)
    );

    for (genvar i = 0; i < NUM_PAT; i++) begin : g_lane
        bankreg_patlane #(.IDX(i)) u_lane (
            .wide  (cfg[ALT_BIT]),
            .sel   (stb.pat),
            .wdata (wdata),
            .cur   (state_q.pat[i]),
            .nxt   (pat_nxt[i])
        );
    end

    always_comb begin
        state_d     = state_q;
        state_d.ctl = ctl_nxt;
        state_d.pat = pat_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign prg_a_o     = state_q.ctl.prg_a;
    assign prg_b_o     = state_q.ctl.prg_b;
    assign prg_win_o   = state_q.ctl.prg_win;
    assign prg_mode_o  = state_q.ctl.prg_mode;
    assign mirror_o    = state_q.ctl.mirror;
    assign rom_lo_en_o = state_q.ctl.rom_lo_en;
    assign irq_en_o    = state_q.ctl.irq_en;
    assign pat_bank_o  = state_q.pat;
endmodule

// File: rtl/bankreg_checker.sv
module bankreg_checker #(
    parameter logic [3:0] PAGE_ID = 4'h8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [15:0] addr,
    input logic [7:0]  wdata,
    input logic [7:0]  cfg,
    input logic [7:0]  prg_a_o,
    input logic [7:0]  prg_b_o,
    input logic [7:0]  prg_win_o,
    input logic [2:0]  prg_mode_o,
    input logic [1:0]  mirror_o,
    input logic        rom_lo_en_o,
    input logic        irq_en_o,
    input logic [71:0] pat_bank_o
);
    logic hit;
    assign hit = wr_en && (addr[15:12] == PAGE_ID);

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(prg_a_o) && $stable(prg_b_o) && $stable(prg_win_o) &&
                 $stable(prg_mode_o) && $stable(mirror_o) && $stable(rom_lo_en_o) &&
                 $stable(irq_en_o) && $stable(pat_bank_o));

    assert_nibble_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit && addr[9:8] == 2'b00 |=> prg_a_o[4:1] == $past(wdata[3:0]) &&
            prg_a_o[7:5] == $past(prg_a_o[7:5]) && prg_a_o[0] == $past(prg_a_o[0]));

    assert_ctrl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hit && addr[9:8] == 2'b01 |=> mirror_o == $past(wdata[1:0]) &&
            prg_mode_o[2] == $past(wdata[4]) && rom_lo_en_o == $past(wdata[5]) &&
            irq_en_o == $past(wdata[7]) && $stable(prg_mode_o[1:0]));

    assert_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit && addr[9:8] == 2'b10 && addr[1:0] == 2'b11 |=>
            prg_win_o == $past(wdata) && $stable(prg_a_o) && $stable(prg_b_o));

    assert_plain_bank0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit && addr[9:8] == 2'b11 && !cfg[2] && addr[2:0] == 3'd0 |=>
            pat_bank_o[7:0] == $past(wdata) && pat_bank_o[8] == $past(pat_bank_o[8]));

    assert_wide_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hit && addr[9:8] == 2'b11 && cfg[2] && addr[2:0] >= 3'd2 && addr[2:0] <= 3'd5
            |=> $stable(pat_bank_o));

    assert_wide_bank6_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit && addr[9:8] == 2'b11 && cfg[2] && addr[2:0] == 3'd7 |=>
            pat_bank_o[62:55] == $past(wdata) && pat_bank_o[54] == $past(pat_bank_o[54]));
endmodule

bind bankreg_regfile bankreg_checker #(.PAGE_ID(PAGE_ID)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .cfg(cfg),
    .prg_a_o(prg_a_o), .prg_b_o(prg_b_o), .prg_win_o(prg_win_o),
    .prg_mode_o(prg_mode_o), .mirror_o(mirror_o), .rom_lo_en_o(rom_lo_en_o),
    .irq_en_o(irq_en_o), .pat_bank_o(pat_bank_o)
);

// File: tb/sim_bankreg_regfile.sv
`timescale 1ns/1ps
module sim_bankreg_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  cfg = '0;
    logic [7:0]  prg_a_o, prg_b_o, prg_win_o;
    logic [2:0]  prg_mode_o;
    logic [1:0]  mirror_o;
    logic        rom_lo_en_o, irq_en_o;
    logic [71:0] pat_bank_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] m_pa, m_pb, m_pw;
    logic [2:0] m_mode;
    logic [1:0] m_mir;
    logic       m_rom, m_irq;
    logic [8:0] m_pat [8];

    always #4 clk = ~clk;

    bankreg_regfile u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .cfg(cfg),
        .prg_a_o(prg_a_o), .prg_b_o(prg_b_o), .prg_win_o(prg_win_o),
        .prg_mode_o(prg_mode_o), .mirror_o(mirror_o), .rom_lo_en_o(rom_lo_en_o),
        .irq_en_o(irq_en_o), .pat_bank_o(pat_bank_o)
    );

    task automatic model_clear();
        m_pa = 0; m_pb = 0; m_pw = 0; m_mode = 0; m_mir = 0; m_rom = 0; m_irq = 0;
        for (int i = 0; i < 8; i++) m_pat[i] = 0;
    endtask

    task automatic model_write(input logic en, input logic [15:0] a,
                               input logic [7:0] d, input logic [7:0] c);
        int slot;
        if (!en || a[15:12] != 4'h8) return;
        slot = int'(a[2:0]);
        if (a[9:8] == 2'd0) m_pa[4:1] = d[3:0];
        else if (a[9:8] == 2'd1) begin
            m_mir = d[1:0]; m_mode[2] = d[4]; m_rom = d[5]; m_irq = d[7];
        end else if (a[9:8] == 2'd2) begin
            if (a[1:0] == 2'd0) m_pa = d;
            else if (a[1:0] == 2'd3) m_pw = d;
            else m_pb = d;
        end else if (!c[2]) m_pat[slot][7:0] = d;
        else if (slot == 0) m_pat[0][8:1] = d;
        else if (slot == 1) m_pat[2][8:1] = d;
        else if (slot == 6) m_pat[4][8:1] = d;
        else if (slot == 7) m_pat[6][8:1] = d;
    endtask

    task automatic compare(input string tag);
        bit bad = 0;
        checks++;
        if (prg_a_o !== m_pa) begin bad = 1; $display("FAIL %s prg_a got %h exp %h", tag, prg_a_o, m_pa); end
        if (prg_b_o !== m_pb) begin bad = 1; $display("FAIL %s prg_b got %h exp %h", tag, prg_b_o, m_pb); end
        if (prg_win_o !== m_pw) begin bad = 1; $display("FAIL %s prg_win got %h exp %h", tag, prg_win_o, m_pw); end
        if (prg_mode_o !== m_mode) begin bad = 1; $display("FAIL %s mode got %h exp %h", tag, prg_mode_o, m_mode); end
        if (mirror_o !== m_mir) begin bad = 1; $display("FAIL %s mirror got %h exp %h", tag, mirror_o, m_mir); end
        if (rom_lo_en_o !== m_rom) begin bad = 1; $display("FAIL %s rom_lo got %b exp %b", tag, rom_lo_en_o, m_rom); end
        if (irq_en_o !== m_irq) begin bad = 1; $display("FAIL %s irq_en got %b exp %b", tag, irq_en_o, m_irq); end
        for (int i = 0; i < 8; i++)
            if (pat_bank_o[9*i +: 9] !== m_pat[i]) begin
                bad = 1;
                $display("FAIL %s pat%0d got %h exp %h", tag, i, pat_bank_o[9*i +: 9], m_pat[i]);
            end
        if (bad) errors++;
    endtask

    // drive at a falling edge, model at the rising edge, compare at the next falling edge
    task automatic step(input logic en, input logic [15:0] a, input logic [7:0] d,
                        input logic [7:0] c, input string tag);
        wr_en = en; addr = a; wdata = d; cfg = c;
        @(posedge clk);
        model_write(en, a, d, c);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1 reset values");

        // R3 nibble write keeps the outer bits
        step(1, 16'h8200, 8'hA5, 8'h00, "R5 prg_a byte");
        step(1, 16'h8000, 8'hF3, 8'h00, "R3 nibble into prg_a");
        step(1, 16'h8055, 8'h0C, 8'h00, "R3 nibble other low addr");
        // R4 control port
        step(1, 16'h8100, 8'hB3, 8'h00, "R4 control all set");
        step(1, 16'h81FF, 8'h4C, 8'h00, "R4 control cleared");
        // R5 program byte port
        step(1, 16'h8201, 8'h11, 8'h00, "R5 prg_b via 01");
        step(1, 16'h8202, 8'h22, 8'h00, "R5 prg_b via 10");
        step(1, 16'h8203, 8'h33, 8'h00, "R5 window bank");
        // R6 plain pattern layout
        for (int k = 0; k < 8; k++)
            step(1, 16'h8300 + 16'(k), 8'(8'h90 + k), 8'h00, "R6 plain pattern bank");
        // R7 wide layout, mapped sub-addresses
        step(1, 16'h8300, 8'hFF, 8'h04, "R7 wide sub 0");
        step(1, 16'h8301, 8'h81, 8'h04, "R7 wide sub 1");
        step(1, 16'h8306, 8'h7E, 8'h04, "R7 wide sub 6");
        step(1, 16'h8307, 8'hC3, 8'h04, "R7 wide sub 7");
        for (int k = 2; k < 6; k++)
            step(1, 16'h8300 + 16'(k), 8'h5A, 8'h04, "R7 wide sub ignored");
        // R6 plain write after a wide one keeps bit 8
        step(1, 16'h8300, 8'h00, 8'h00, "R6 bit 8 kept");
        // R8 flag sampled per write
        step(1, 16'h8301, 8'hEE, 8'h00, "R8 plain then");
        step(1, 16'h8301, 8'h12, 8'hFB, "R8 flag clear other cfg bits");
        step(1, 16'h8301, 8'h34, 8'h04, "R8 wide now");
        // R2 writes that must not land
        step(0, 16'h8300, 8'hAA, 8'h00, "R2 no strobe");
        step(1, 16'h9300, 8'hAA, 8'h00, "R2 page 9");
        step(1, 16'h0203, 8'hAA, 8'h00, "R2 page 0");
        step(1, 16'h7100, 8'hAA, 8'h04, "R2 page 7");
        step(0, 16'h8000, 8'hFF, 8'h04, "R2 idle nibble");

        for (int n = 0; n < 4000; n++) begin
            logic [15:0] a;
            logic [3:0]  pg;
            pg = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(6, 10)) : 4'h8;
            a = {pg, 2'b00, 2'($urandom), 1'b0, 4'($urandom), 3'($urandom)};
            step(1'($urandom_range(0, 4) != 0), a, 8'($urandom), 8'($urandom), "random mix");
        end

        rst_n = 1'b0;
        @(posedge clk);
        model_clear();
        @(negedge clk);
        rst_n = 1'b1;
        compare("R1 reset after traffic");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule